// File: doc/BRIEF.md
# Supply Over-Current Trip Filter

This block decides when each of several switched supply channels must have its pass-transistor gate turned off because of excess current. Every channel receives two asynchronous comparator flags from analog circuitry: a moderate over-current flag, which must persist for a programmable time before it counts, and a severe over-current flag, which acts at once unless that channel's severe threshold is set to off. A tripped channel stays latched off until a clear pulse arrives from the sequencing logic.

A shared fault line with selectable polarity reports that any channel has tripped. When crowbar firing on severe trips is enabled, a severe trip also fires a fixed-width crowbar strobe and turns off every gate until the next clear. A force-shutdown input with selectable active level turns off all gates for as long as it is asserted. Timing runs from a microsecond tick that the block derives from its clock by a prescaler.

Top module: `ocp_trip_guard`

## Requirements
- R1: The shared filter select `delay_sel` sets the persistence time: 2'b00 = 25 us, 2'b01 = 50 us, 2'b10 = 100 us, 2'b11 = 200 us. A moderate flag held steadily sets that channel's `oc_status` after N microsecond ticks, where N is the selected number of microseconds. This takes between (N-1) and N microseconds plus three clock cycles after the raw flag rises.
- R2: When the synchronized moderate flag drops, the persistence count for that channel restarts from zero. Repeated excursions that are each shorter than the selected time never trip, however long they add up to.
- R3: With a channel's 2-bit severe code (bits [2i+1:2i] of `qt_code`) non-zero (01, 10 or 11), a severe flag held across one clock edge sets that channel's `oc_status` and `gate_off` on the third rising edge after the raw flag rises. No tick is involved.
- R4: With a channel's severe code equal to 2'b00, that channel's severe flag has no effect on `oc_status`, `gate_off` or `crowbar_out`.
- R5: A trip stays latched while the flags are gone. A one-cycle `trip_clear` returns every `oc_status` bit and every crowbar-caused `gate_off` bit to 0 on the next edge; the clear takes priority over a trip in the same cycle.
- R6: `fault_out` is active whenever any `oc_status` bit is 1. It is active high when `fault_pol` = 1 and active low when `fault_pol` = 0.
- R7: With `crowbar_qt_en` = 1, a severe trip on a channel that had not already tripped starts a `crowbar_out` strobe of CROWBAR_US ticks, which is 19 to 20 us at the default. It also sets all `gate_off` bits until `trip_clear`. A new severe trip during a running strobe does not extend it.
- R8: With `crowbar_qt_en` = 0, a severe trip produces no strobe and turns off only its own channel.
- R9: While `force_sd_in` equals `force_sd_pol`, every `gate_off` bit is 1 in the same cycle. Nothing is latched, so the bits fall once the force is released.
- R10: After reset every `gate_off`, `oc_status` and `crowbar_out` bit is 0 and `fault_out` shows the inactive level.
- R11: Channels are independent. A trip without crowbar action changes only that channel's `oc_status` and `gate_off` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (CLK_PER_US cycles per microsecond) |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_oc_raw | input | NUM_CH | Asynchronous moderate over-current flags, one per channel |
| fast_oc_raw | input | NUM_CH | Asynchronous severe over-current flags, one per channel |
| delay_sel | input | 2 | Shared persistence-time select |
| qt_code | input | 2*NUM_CH | Per-channel severe threshold code, 00 = off |
| fault_pol | input | 1 | 1 = fault_out active high, 0 = active low |
| crowbar_qt_en | input | 1 | Severe trips fire the crowbar and turn off all gates |
| force_sd_in | input | 1 | Force-shutdown request |
| force_sd_pol | input | 1 | Level of force_sd_in that counts as asserted |
| trip_clear | input | 1 | Synchronous clear of all latched trips |
| gate_off | output | NUM_CH | Per-channel gate disable, 1 = gate off |
| oc_status | output | NUM_CH | Per-channel latched over-current status |
| fault_out | output | 1 | Shared fault indication, polarity per fault_pol |
| crowbar_out | output | 1 | Crowbar strobe, active high |

## Verification
The hardest case to reach is the one where the persistence filter must reject a moderate flag whose total on-time is far beyond the selected delay. This only happens when the flag is broken into short bursts with low gaps that are long enough to pass the two synchronizer stages. The stimulus holds the flag for 15 us at a time and then drops it for three clocks, four times over at the 25 us setting. A cycle-accurate reference model follows the phase of the free-running prescaler. With that model, the trip instant for each delay code and the width of the crowbar strobe are each checked to the exact cycle, and also against a window written in microseconds.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  localparam int LIM_W = 8;

  // persistence time in microseconds for a delay select code
  function automatic logic [LIM_W-1:0] filter_limit_us(input logic [1:0] sel);
    logic [LIM_W-1:0] us;
    case (sel)
      2'b00:   us = LIM_W'(25);
      2'b01:   us = LIM_W'(50);
      2'b10:   us = LIM_W'(100);
      default: us = LIM_W'(200);
    endcase
    return us;
  endfunction

  // a severe-trip code arms the channel unless it is the off code
  function automatic logic qt_armed(input logic [1:0] code);
    return code != 2'b00;
  endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ocp_us_tick.sv
module ocp_us_tick #(
  parameter int CLK_PER_US = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else           pre <= pre + PW'(1);
  end

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ocp_chan_filter.sv
module ocp_chan_filter
  import ocp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             slow_s,
  input  logic             fast_s,
  input  logic [1:0]       qt_code,
  input  logic [LIM_W-1:0] limit,
  input  logic             trip_clear,
  output logic             tripped,
  output logic             slow_evt,
  output logic             fast_evt,
  output logic             qt_new
);
  logic [LIM_W-1:0] cnt;
  logic [LIM_W-1:0] lim_m1;

  assign lim_m1   = limit - LIM_W'(1);
  assign fast_evt = fast_s & qt_armed(qt_code);
  assign slow_evt = slow_s & tick & (cnt >= lim_m1);
  assign qt_new   = fast_evt & ~tripped;

  // persistence counter: restarts whenever the flag is absent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!slow_s)               cnt <= '0;
    else if (tick && cnt < lim_m1)  cnt <= cnt + LIM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     tripped <= 1'b0;
    else if (trip_clear)            tripped <= 1'b0;
    else if (slow_evt || fast_evt)  tripped <= 1'b1;
  end

  assert_trip_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped) |-> $past(slow_evt || fast_evt));

  assert_off_code_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tripped) && $past(qt_code) == 2'b00) |-> $past(slow_evt));

  assert_count_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_s |=> cnt == '0);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !trip_clear) |=> tripped);
endmodule

// File: rtl/ocp_crowbar.sv
module ocp_crowbar #(
  parameter int PULSE_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic trip_clear,
  output logic strobe,
  output logic shut_all
);
  localparam int CW = $clog2(PULSE_US + 1);

  logic [CW-1:0] cnt;

  assign strobe = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == '0) begin
      if (start)          cnt <= CW'(PULSE_US);
    end else if (tick)    cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          shut_all <= 1'b0;
    else if (trip_clear) shut_all <= 1'b0;
    else if (start)      shut_all <= 1'b1;
  end

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(start));

  assert_width_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PULSE_US));

  assert_no_extend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !tick) |=> $stable(cnt));
endmodule

// File: rtl/ocp_trip_guard.sv
module ocp_trip_guard
  import ocp_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CLK_PER_US = 8,
  parameter int CROWBAR_US = 20,
  parameter int SYNC_STG   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   slow_oc_raw,
  input  logic [NUM_CH-1:0]   fast_oc_raw,
  input  logic [1:0]          delay_sel,
  input  logic [2*NUM_CH-1:0] qt_code,
  input  logic                fault_pol,
  input  logic                crowbar_qt_en,
  input  logic                force_sd_in,
  input  logic                force_sd_pol,
  input  logic                trip_clear,
  output logic [NUM_CH-1:0]   gate_off,
  output logic [NUM_CH-1:0]   oc_status,
  output logic                fault_out,
  output logic                crowbar_out
);
  logic [NUM_CH-1:0] slow_s, fast_s;
  logic [NUM_CH-1:0] tripped, slow_evt, fast_evt, qt_new;
  logic              tick, cb_start, shut_all, force_hit, any_oc;
  logic [LIM_W-1:0]  limit;

  ocp_sync #(.W(NUM_CH), .STAGES(SYNC_STG)) u_sync_slow (
    .clk(clk), .rst_n(rst_n), .d(slow_oc_raw), .q(slow_s));
  ocp_sync #(.W(NUM_CH), .STAGES(SYNC_STG)) u_sync_fast (
    .clk(clk), .rst_n(rst_n), .d(fast_oc_raw), .q(fast_s));

  ocp_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  assign limit = filter_limit_us(delay_sel);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ocp_chan_filter u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .slow_s(slow_s[i]), .fast_s(fast_s[i]),
        .qt_code(qt_code[2*i +: 2]), .limit(limit),
        .trip_clear(trip_clear),
        .tripped(tripped[i]), .slow_evt(slow_evt[i]),
        .fast_evt(fast_evt[i]), .qt_new(qt_new[i]));
    end
  endgenerate

  assign cb_start = crowbar_qt_en & (|qt_new);

  ocp_crowbar #(.PULSE_US(CROWBAR_US)) u_cb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(cb_start),
    .trip_clear(trip_clear), .strobe(crowbar_out), .shut_all(shut_all));

  assign force_hit   = (force_sd_in == force_sd_pol);
  assign any_oc      = |tripped;
  assign oc_status   = tripped;
  assign fault_out   = fault_pol ? any_oc : ~any_oc;
  assign gate_off    = tripped | {NUM_CH{shut_all | force_hit}};

  assert_force_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_sd_in == force_sd_pol) |-> (&gate_off));

  assert_fault_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_status) |-> (fault_out == fault_pol));

  assert_clear_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trip_clear |=> (oc_status == '0));

  assert_gate_covers_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off & oc_status) == oc_status);

  assert_severe_needs_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crowbar_out) |-> $past(crowbar_qt_en && (|fast_evt)));
endmodule

// File: tb/ocp_trip_guard_tb.sv
module ocp_trip_guard_tb_top;
  localparam int NCH = 4;
  localparam int CPU = 8;
  localparam int CBU = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] slow_oc_raw = '0, fast_oc_raw = '0;
  logic [1:0] delay_sel = 2'b00;
  logic [2*NCH-1:0] qt_code = '0;
  logic fault_pol = 1'b0, crowbar_qt_en = 1'b0;
  logic force_sd_in = 1'b1, force_sd_pol = 1'b0, trip_clear = 1'b0;
  logic [NCH-1:0] gate_off, oc_status;
  logic fault_out, crowbar_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ocp_trip_guard #(.NUM_CH(NCH), .CLK_PER_US(CPU), .CROWBAR_US(CBU)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_oc_raw(slow_oc_raw), .fast_oc_raw(fast_oc_raw),
    .delay_sel(delay_sel), .qt_code(qt_code), .fault_pol(fault_pol),
    .crowbar_qt_en(crowbar_qt_en), .force_sd_in(force_sd_in),
    .force_sd_pol(force_sd_pol), .trip_clear(trip_clear),
    .gate_off(gate_off), .oc_status(oc_status), .fault_out(fault_out),
    .crowbar_out(crowbar_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int us_of(input logic [1:0] sel);
    return 25 << sel;
  endfunction

  // behavioural reference model
  int m_pre, m_cb;
  int m_cnt [NCH];
  bit m_trip [NCH];
  bit m_s1s [NCH], m_s2s [NCH], m_s1f [NCH], m_s2f [NCH];
  bit m_all;

  always @(posedge clk) begin
    bit tk, st, fe, se;
    int lim;
    if (!rst_n) begin
      m_pre = 0; m_cb = 0; m_all = 0;
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = 0; m_trip[i] = 0; m_s1s[i] = 0; m_s2s[i] = 0; m_s1f[i] = 0; m_s2f[i] = 0;
      end
    end else begin
      tk = (m_pre == CPU - 1);
      lim = us_of(delay_sel);
      st = 0;
      for (int i = 0; i < NCH; i++) begin
        fe = m_s2f[i] && (qt_code[2*i +: 2] != 2'b00);
        se = m_s2s[i] && tk && (m_cnt[i] >= lim - 1);
        if (fe && !m_trip[i] && crowbar_qt_en) st = 1;
        if (trip_clear) m_trip[i] = 0;
        else if (fe || se) m_trip[i] = 1;
        if (!m_s2s[i]) m_cnt[i] = 0;
        else if (tk && m_cnt[i] < lim - 1) m_cnt[i]++;
        m_s2s[i] = m_s1s[i]; m_s1s[i] = slow_oc_raw[i];
        m_s2f[i] = m_s1f[i]; m_s1f[i] = fast_oc_raw[i];
      end
      if (trip_clear) m_all = 0; else if (st) m_all = 1;
      if (m_cb == 0) begin if (st) m_cb = CBU; end
      else if (tk) m_cb--;
      m_pre = tk ? 0 : m_pre + 1;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    logic [NCH-1:0] e_oc, e_g;
    bit e_any, e_f;
    #2;
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) e_oc[i] = m_trip[i];
      e_any = |e_oc;
      e_f = (force_sd_in == force_sd_pol);
      e_g = e_oc | {NCH{m_all | e_f}};
      chk(oc_status == e_oc, "R5 oc_status", int'(oc_status), int'(e_oc));
      chk(gate_off == e_g, "R11 gate_off", int'(gate_off), int'(e_g));
      chk(fault_out == (fault_pol ? e_any : !e_any), "R6 fault_out", int'(fault_out),
          int'(fault_pol ? e_any : !e_any));
      chk(crowbar_out == (m_cb != 0), "R7 crowbar_out", int'(crowbar_out), int'(m_cb != 0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); trip_clear = 1'b1;
    @(negedge clk); trip_clear = 1'b0;
  endtask

  initial begin
    int c, w;
    run(3);
    rst_n = 1'b1;
    run(1);
    // R10 reset state
    chk(gate_off == 0, "R10 gate_off", int'(gate_off), 0);
    chk(oc_status == 0, "R10 oc_status", int'(oc_status), 0);
    chk(crowbar_out == 0, "R10 crowbar_out", int'(crowbar_out), 0);
    chk(fault_out == 1, "R10 fault_out inactive", int'(fault_out), 1);

    // R1 each persistence setting
    for (int s = 0; s < 4; s++) begin
      delay_sel = 2'(s);
      slow_oc_raw[0] = 1'b1;
      c = 0;
      while (!oc_status[0] && c < 3000) begin @(negedge clk); c++; end
      chk(c >= (us_of(2'(s)) - 1) * CPU + 3 && c <= us_of(2'(s)) * CPU + 3,
          "R1 trip time cycles", c, us_of(2'(s)) * CPU);
      chk(gate_off == 4'b0001, "R11 only channel 0 off", int'(gate_off), 1);
      slow_oc_raw[0] = 1'b0;
      run(5);
      chk(oc_status[0] == 1'b1, "R5 trip held", int'(oc_status[0]), 1);
      do_clear();
      run(1);
      chk(oc_status == 0, "R5 clear", int'(oc_status), 0);
    end

    // R2 bursts shorter than the delay
    delay_sel = 2'b00;
    for (int k = 0; k < 4; k++) begin
      slow_oc_raw[2] = 1'b1; run(15 * CPU);
      slow_oc_raw[2] = 1'b0; run(3);
    end
    chk(oc_status == 0, "R2 bursts no trip", int'(oc_status), 0);
    slow_oc_raw[2] = 1'b1; run(30 * CPU);
    chk(oc_status[2] == 1'b1, "R2 steady trips", int'(oc_status[2]), 1);
    slow_oc_raw[2] = 1'b0; do_clear(); run(2);

    // R3 severe trip, no crowbar (R8), polarity (R6)
    qt_code = 8'b00_00_01_00;
    @(negedge clk); fast_oc_raw[1] = 1'b1;
    @(negedge clk); fast_oc_raw[1] = 1'b0;
    chk(oc_status[1] == 1'b0, "R3 not before third edge", int'(oc_status[1]), 0);
    run(2);
    chk(oc_status == 4'b0010, "R3 severe trip", int'(oc_status), 2);
    chk(gate_off == 4'b0010, "R11 other channels on", int'(gate_off), 2);
    chk(crowbar_out == 1'b0, "R8 no strobe", int'(crowbar_out), 0);
    chk(fault_out == 1'b0, "R6 active low", int'(fault_out), 0);
    fault_pol = 1'b1; run(1);
    chk(fault_out == 1'b1, "R6 active high", int'(fault_out), 1);
    do_clear(); run(1);
    chk(fault_out == 1'b0, "R6 inactive high-pol", int'(fault_out), 0);
    fault_pol = 1'b0;

    // R4 off code ignored, other codes trip
    qt_code = 8'b11_00_00_00;
    fast_oc_raw[2] = 1'b1; fast_oc_raw[3] = 1'b1; run(40);
    chk(oc_status[2] == 1'b0 && gate_off[2] == 1'b0, "R4 off code ignored",
        int'(oc_status[2]), 0);
    chk(oc_status[3] == 1'b1, "R3 code 11 trips", int'(oc_status[3]), 1);
    qt_code = 8'b11_10_00_00; run(4);
    chk(oc_status[2] == 1'b1, "R3 code 10 trips", int'(oc_status[2]), 1);
    fast_oc_raw = '0; do_clear(); run(2);

    // R7 crowbar strobe
    crowbar_qt_en = 1'b1; qt_code = 8'b00_00_00_11;
    @(negedge clk); fast_oc_raw[0] = 1'b1;
    @(negedge clk); fast_oc_raw[0] = 1'b0;
    c = 0;
    while (!crowbar_out && c < 20) begin @(negedge clk); c++; end
    chk(gate_off == 4'b1111, "R7 all gates off", int'(gate_off), 15);
    w = 0;
    while (crowbar_out && w < 1000) begin @(negedge clk); w++; end
    chk(w >= (CBU - 1) * CPU + 1 && w <= CBU * CPU, "R7 strobe width", w, CBU * CPU);
    chk(gate_off == 4'b1111, "R7 shutdown latched", int'(gate_off), 15);
    do_clear(); run(1);
    chk(gate_off == 0, "R5 clear after crowbar", int'(gate_off), 0);
    crowbar_qt_en = 1'b0; qt_code = '0;

    // R9 force shutdown both polarities
    force_sd_pol = 1'b1; force_sd_in = 1'b1; run(1);
    chk(gate_off == 4'b1111, "R9 force high level", int'(gate_off), 15);
    force_sd_in = 1'b0; run(1);
    chk(gate_off == 0, "R9 released", int'(gate_off), 0);
    force_sd_pol = 1'b0; run(1);
    chk(gate_off == 4'b1111, "R9 force low level", int'(gate_off), 15);
    force_sd_in = 1'b1; run(2);
    chk(gate_off == 0 && oc_status == 0, "R9 no latch", int'(gate_off), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule